// File: doc/BRIEF.md
# Low-Byte Address Generator with Stack Pointer

This unit produces the lower eight bits of the address of a small 8-bit processor. It owns two registers: the low byte of the program counter and the stack pointer. A five-bit operation code from the sequencer selects, each cycle, what the low address byte becomes. The choices are the program counter (plain or incremented), a zero-page byte taken from the data bus with or without an index, the low half of an indexed absolute address, a relative branch target, or a stack slot. The unit's own adder does all of this arithmetic.

The index value arrives on a side bus shared with the data ALU. The same bus runs the other way when the stack pointer is copied out to a register. Two carry flags and a direction flag tell the companion high-byte unit whether its half of the address, or of the program counter, must step. The low program-counter byte can be placed on the data bus so that a subroutine call or interrupt can push it. All state advances only in cycles where `rdy` is high. Indexed zero-page and page-crossing forms take no extra cycle.

Top module: `addr_lo_unit`

## Requirements
- R1: A synchronous active-high `rst` sets `ab_lo` to parameter `VEC_LO` (default 0xFC), clears the PC low byte to 0 and clears `ab_carry`, `ab_down`, `pc_carry` and `db_oe`. The stack pointer keeps its value across reset.
- R2: Operation codes on `aop` are 0 hold, 1 present PC, 2 increment PC, 3 zero page, 4 zero-page indexed, 5 absolute indexed low, 6 load PC, 7 branch, 8 push, 9 pull, 10 push PC low, 11 stack to side bus, 12 side bus to stack. Codes 13 to 31 act as 0. Hold keeps `ab_lo`, PC and SP and clears all three flags. Each code takes effect at the rising edge of a cycle with `rdy` high. Flags are cleared by every code that does not name them.
- R3: Code 2 sets PC and `ab_lo` to PC+1 modulo 256. `pc_carry` is 1 exactly when PC was 0xFF.
- R4: Code 3 sets `ab_lo` to `db_in`. Code 4 sets it to (`db_in` + `sb_in`) modulo 256 with `ab_carry` 0.
- R5: Code 5 sets `ab_lo` to the low eight bits of `db_in` + `sb_in`, sets `ab_carry` to the carry out, and sets `ab_down` to 0.
- R6: Code 6 loads PC and `ab_lo` from `db_in`. Code 1 copies PC to `ab_lo` and leaves PC unchanged.
- R7: Code 7 adds `db_in` as a signed offset to PC and writes the low result to PC and `ab_lo`. `ab_down` takes the offset sign. `ab_carry` is 1 when the target leaves the current page: a carry out for a positive offset, no carry out for a negative one.
- R8: Code 8 puts SP on `ab_lo` and then decrements SP. Code 9 increments SP and puts the new SP on `ab_lo`.
- R9: Code 10 acts as a push and, in the following cycle, drives `db_oe` high with `db_out` equal to the PC byte at the push edge. The next accepted code clears `db_oe`, and a PC change in that cycle does not alter `db_out`.
- R10: While `aop` is 11, `sb_oe` is 1 and `sb_out` equals SP in the same cycle. With any other code `sb_oe` is 0.
- R11: Code 12 loads SP from `sb_in`.
- R12: While `rdy` is low, PC, SP, `ab_lo`, all flags, `db_oe` and `db_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy | input | 1 | Cycle enable; low freezes all state |
| aop | input | 5 | Address operation code |
| db_in | input | 8 | Data bus value seen by the unit |
| db_out | output | 8 | PC low byte driven for a push |
| db_oe | output | 1 | Data bus drive enable |
| sb_in | input | 8 | Side bus from the ALU (index or new SP) |
| sb_out | output | 8 | Stack pointer driven to the ALU |
| sb_oe | output | 1 | Side bus drive enable |
| ab_lo | output | 8 | Low address byte |
| ab_carry | output | 1 | Address page step request to the high unit |
| ab_down | output | 1 | Direction of that step (1 = decrement) |
| pc_carry | output | 1 | PC high increment request |

## Verification
Two functions share a cycle in this unit. The first is the data-bus drive of a pushed PC byte, which happens in the cycle after the push code. The second is whatever code the sequencer issues in that same cycle, often a PC reload. The bench issues a push of the PC byte followed at once by a load of a new PC. It checks that `db_out` still carries the pushed byte while the address follows the new code. It also stalls with `rdy` low during the drive cycle to confirm that the drive stays up until the next accepted code. A reference model written from the requirements predicts every registered output after each edge.

// File: rtl/addr_lo_pkg.sv
package addr_lo_pkg;

    localparam int LO_W = 8;
    localparam int OP_W = 5;

    typedef logic [LO_W-1:0] lo_t;
    typedef logic [LO_W:0]   lo_c_t;   // carry in the top bit

    typedef enum logic [OP_W-1:0] {
        AOP_HOLD     = 5'd0,
        AOP_PC_OUT   = 5'd1,
        AOP_PC_INC   = 5'd2,
        AOP_ZP       = 5'd3,
        AOP_ZP_IDX   = 5'd4,
        AOP_ABS_IDX  = 5'd5,
        AOP_LOAD_PC  = 5'd6,
        AOP_BRANCH   = 5'd7,
        AOP_PUSH     = 5'd8,
        AOP_PULL     = 5'd9,
        AOP_PUSH_PCL = 5'd10,
        AOP_SP_OUT   = 5'd11,
        AOP_SP_IN    = 5'd12
    } aop_e;

    typedef enum logic [2:0] {
        SRC_KEEP, SRC_PCL, SRC_PC_INC, SRC_DB,
        SRC_IDX, SRC_BR, SRC_SP, SRC_SP_INC
    } ab_src_e;

    typedef enum logic [1:0] {CY_NONE, CY_PC, CY_IDX, CY_BR} cy_sel_e;

    typedef struct packed {
        lo_t  sum;
        logic carry;   // page left
        logic down;    // direction of the page step
    } lo_rel_t;

    typedef struct packed {
        ab_src_e ab_src;
        cy_sel_e cy_sel;
        logic    pcl_inc;
        logic    pcl_ld_db;
        logic    pcl_ld_br;
        logic    sp_push;
        logic    sp_pull;
        logic    sp_load;
        logic    push_pcl;
        logic    sb_drive;
    } ctl_t;

    function automatic lo_c_t add_plain(lo_t a, lo_t b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    function automatic lo_rel_t add_rel(lo_t base, lo_t off);
        lo_rel_t r;
        lo_c_t   s;
        s       = {1'b0, base} + {1'b0, off};
        r.sum   = s[LO_W-1:0];
        r.down  = off[LO_W-1];
        r.carry = r.down ? ~s[LO_W] : s[LO_W];
        return r;
    endfunction

    function automatic ctl_t decode(logic [OP_W-1:0] code);
        ctl_t c;
        c = '0;
        case (code)
            AOP_PC_OUT:   c.ab_src = SRC_PCL;
            AOP_PC_INC: begin
                c.ab_src  = SRC_PC_INC;
                c.cy_sel  = CY_PC;
                c.pcl_inc = 1'b1;
            end
            AOP_ZP:       c.ab_src = SRC_DB;
            AOP_ZP_IDX:   c.ab_src = SRC_IDX;
            AOP_ABS_IDX: begin
                c.ab_src = SRC_IDX;
                c.cy_sel = CY_IDX;
            end
            AOP_LOAD_PC: begin
                c.ab_src    = SRC_DB;
                c.pcl_ld_db = 1'b1;
            end
            AOP_BRANCH: begin
                c.ab_src    = SRC_BR;
                c.cy_sel    = CY_BR;
                c.pcl_ld_br = 1'b1;
            end
            AOP_PUSH: begin
                c.ab_src  = SRC_SP;
                c.sp_push = 1'b1;
            end
            AOP_PULL: begin
                c.ab_src  = SRC_SP_INC;
                c.sp_pull = 1'b1;
            end
            AOP_PUSH_PCL: begin
                c.ab_src   = SRC_SP;
                c.sp_push  = 1'b1;
                c.push_pcl = 1'b1;
            end
            AOP_SP_OUT:   c.sb_drive = 1'b1;
            AOP_SP_IN:    c.sp_load  = 1'b1;
            default:      c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/addr_lo_arith.sv
module addr_lo_arith
    import addr_lo_pkg::*;
(
    input  lo_t     pcl,
    input  lo_t     sp,
    input  lo_t     db,
    input  lo_t     sb,
    output lo_c_t   pc_next,
    output lo_c_t   idx_sum,
    output lo_rel_t br_sum,
    output lo_t     sp_up,
    output lo_t     sp_dn
);

    assign pc_next = add_plain(pcl, lo_t'(1));
    assign idx_sum = add_plain(db, sb);
    assign br_sum  = add_rel(pcl, db);
    assign sp_up   = sp + lo_t'(1);
    assign sp_dn   = sp - lo_t'(1);

endmodule

// File: rtl/addr_lo_stack.sv
module addr_lo_stack
    import addr_lo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rdy,
    input  logic push,
    input  logic pull,
    input  logic load,
    input  lo_t  ld_val,
    input  lo_t  sp_up,
    input  lo_t  sp_dn,
    output lo_t  sp_q
);

    // No reset: the pointer survives a processor reset.
    always_ff @(posedge clk) begin
        if (rdy) begin
            if (load)      sp_q <= ld_val;
            else if (push) sp_q <= sp_dn;
            else if (pull) sp_q <= sp_up;
        end
    end

    p_push_dec_r8: assert property (@(posedge clk) disable iff (rst)
        (rdy && push && !load) |=> sp_q == $past(sp_q) - lo_t'(1));

    p_pull_inc_r8: assert property (@(posedge clk) disable iff (rst)
        (rdy && pull && !load && !push) |=> sp_q == $past(sp_q) + lo_t'(1));

endmodule

// File: rtl/addr_lo_pcreg.sv
module addr_lo_pcreg
    import addr_lo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rdy,
    input  logic inc,
    input  logic ld,
    input  lo_t  ld_val,
    input  lo_t  inc_val,
    output lo_t  pcl_q
);

    always_ff @(posedge clk) begin
        if (rst)           pcl_q <= '0;
        else if (rdy) begin
            if (ld)        pcl_q <= ld_val;
            else if (inc)  pcl_q <= inc_val;
        end
    end

    p_pc_step_r3: assert property (@(posedge clk) disable iff (rst)
        (rdy && inc && !ld) |=> pcl_q == $past(pcl_q) + lo_t'(1));

endmodule

// File: rtl/addr_lo_unit.sv
module addr_lo_unit
    import addr_lo_pkg::*;
#(
    parameter lo_t VEC_LO = 8'hFC
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rdy,
    input  logic [OP_W-1:0] aop,
    input  logic [LO_W-1:0] db_in,
    output logic [LO_W-1:0] db_out,
    output logic            db_oe,
    input  logic [LO_W-1:0] sb_in,
    output logic [LO_W-1:0] sb_out,
    output logic            sb_oe,
    output logic [LO_W-1:0] ab_lo,
    output logic            ab_carry,
    output logic            ab_down,
    output logic            pc_carry
);

    ctl_t    ctl;
    lo_t     pcl_q, sp_q, sp_up, sp_dn;
    lo_c_t   pc_next, idx_sum;
    lo_rel_t br_sum;

    lo_t  ab_q, dout_q;
    logic ab_carry_q, ab_down_q, pc_carry_q, oe_q;

    assign ctl = decode(aop);

    addr_lo_arith u_arith (
        .pcl     (pcl_q),
        .sp      (sp_q),
        .db      (db_in),
        .sb      (sb_in),
        .pc_next (pc_next),
        .idx_sum (idx_sum),
        .br_sum  (br_sum),
        .sp_up   (sp_up),
        .sp_dn   (sp_dn)
    );

    addr_lo_pcreg u_pc (
        .clk     (clk),
        .rst     (rst),
        .rdy     (rdy),
        .inc     (ctl.pcl_inc),
        .ld      (ctl.pcl_ld_db | ctl.pcl_ld_br),
        .ld_val  (ctl.pcl_ld_br ? br_sum.sum : db_in),
        .inc_val (pc_next[LO_W-1:0]),
        .pcl_q   (pcl_q)
    );

    addr_lo_stack u_sp (
        .clk    (clk),
        .rst    (rst),
        .rdy    (rdy),
        .push   (ctl.sp_push),
        .pull   (ctl.sp_pull),
        .load   (ctl.sp_load),
        .ld_val (sb_in),
        .sp_up  (sp_up),
        .sp_dn  (sp_dn),
        .sp_q   (sp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_q       <= VEC_LO;
            ab_carry_q <= 1'b0;
            ab_down_q  <= 1'b0;
            pc_carry_q <= 1'b0;
            oe_q       <= 1'b0;
            dout_q     <= '0;
        end else if (rdy) begin
            case (ctl.ab_src)
                SRC_PCL:    ab_q <= pcl_q;
                SRC_PC_INC: ab_q <= pc_next[LO_W-1:0];
                SRC_DB:     ab_q <= db_in;
                SRC_IDX:    ab_q <= idx_sum[LO_W-1:0];
                SRC_BR:     ab_q <= br_sum.sum;
                SRC_SP:     ab_q <= sp_q;
                SRC_SP_INC: ab_q <= sp_up;
                default:    ab_q <= ab_q;
            endcase
            ab_carry_q <= 1'b0;
            ab_down_q  <= 1'b0;
            pc_carry_q <= 1'b0;
            case (ctl.cy_sel)
                CY_PC:   pc_carry_q <= pc_next[LO_W];
                CY_IDX:  ab_carry_q <= idx_sum[LO_W];
                CY_BR: begin
                    ab_carry_q <= br_sum.carry;
                    ab_down_q  <= br_sum.down;
                end
                default: ;
            endcase
            oe_q <= ctl.push_pcl;
            if (ctl.push_pcl) dout_q <= pcl_q;
        end
    end

    assign ab_lo    = ab_q;
    assign ab_carry = ab_carry_q;
    assign ab_down  = ab_down_q;
    assign pc_carry = pc_carry_q;
    assign db_oe    = oe_q;
    assign db_out   = dout_q;
    assign sb_oe    = ctl.sb_drive;
    assign sb_out   = ctl.sb_drive ? sp_q : '0;

    p_stall_r12: assert property (@(posedge clk) disable iff (rst)
        !rdy |=> $stable(ab_q) && $stable(ab_carry_q) && $stable(ab_down_q)
                 && $stable(pc_carry_q) && $stable(oe_q) && $stable(dout_q));

    p_oe_src_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_q) |-> $past(ctl.push_pcl && rdy));

    p_zp_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (rdy && aop == AOP_ZP_IDX) |=> !ab_carry_q);

    p_rel_dir_r7: assert property (@(posedge clk) disable iff (rst)
        (rdy && aop == AOP_BRANCH) |=> ab_down_q == $past(db_in[LO_W-1]));

endmodule

// File: tb/addr_lo_unit_tb.sv
module addr_lo_unit_tb;
    import addr_lo_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic       rst, rdy;
    logic [4:0] aop;
    logic [7:0] db_in, db_out, sb_in, sb_out, ab_lo;
    logic       db_oe, sb_oe, ab_carry, ab_down, pc_carry;

    addr_lo_unit u_dut (
        .clk(clk), .rst(rst), .rdy(rdy), .aop(aop),
        .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
        .sb_in(sb_in), .sb_out(sb_out), .sb_oe(sb_oe),
        .ab_lo(ab_lo), .ab_carry(ab_carry), .ab_down(ab_down),
        .pc_carry(pc_carry)
    );

    typedef struct {
        logic [7:0] ab;
        logic       ac, ad, pc, oe;
        logic [7:0] dout;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;

    // reference state
    logic [7:0] m_pcl, m_sp, m_ab, m_dout;
    logic       m_ac, m_ad, m_pc, m_oe;

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ab = 8'hFC; m_pcl = 8'h00;
        m_ac = 0; m_ad = 0; m_pc = 0; m_oe = 0; m_dout = 8'h00;
    endtask

    task automatic check_reset();
        cmp("R1", "ab_lo",    ab_lo,          8'hFC);
        cmp("R1", "ab_carry", {7'd0, ab_carry}, 8'd0);
        cmp("R1", "ab_down",  {7'd0, ab_down},  8'd0);
        cmp("R1", "pc_carry", {7'd0, pc_carry}, 8'd0);
        cmp("R1", "db_oe",    {7'd0, db_oe},    8'd0);
    endtask

    // driver: applies one code for one cycle and queues the predicted outputs
    task automatic step(input logic [4:0] op, input logic [7:0] d,
                        input logic [7:0] s, input logic r, input string tag);
        logic [8:0] t;
        exp_t e;
        @(negedge clk);
        aop = op; db_in = d; sb_in = s; rdy = r;
        #1;
        // R10: combinational side-bus drive, same cycle
        cmp("R10", "sb_oe", {7'd0, sb_oe}, {7'd0, op == AOP_SP_OUT});
        if (op == AOP_SP_OUT) cmp("R10", "sb_out", sb_out, m_sp);
        if (r) begin
            m_ac = 0; m_ad = 0; m_pc = 0; m_oe = 0;
            case (op)
                AOP_PC_OUT: m_ab = m_pcl;
                AOP_PC_INC: begin
                    t = {1'b0, m_pcl} + 9'd1;
                    m_pcl = t[7:0]; m_ab = t[7:0]; m_pc = t[8];
                end
                AOP_ZP:     m_ab = d;
                AOP_ZP_IDX: m_ab = d + s;
                AOP_ABS_IDX: begin
                    t = {1'b0, d} + {1'b0, s};
                    m_ab = t[7:0]; m_ac = t[8];
                end
                AOP_LOAD_PC: begin m_pcl = d; m_ab = d; end
                AOP_BRANCH: begin
                    t = {1'b0, m_pcl} + {1'b0, d};
                    m_pcl = t[7:0]; m_ab = t[7:0]; m_ad = d[7];
                    m_ac = d[7] ? ~t[8] : t[8];
                end
                AOP_PUSH:   begin m_ab = m_sp; m_sp = m_sp - 8'd1; end
                AOP_PULL:   begin m_sp = m_sp + 8'd1; m_ab = m_sp; end
                AOP_PUSH_PCL: begin
                    m_ab = m_sp; m_sp = m_sp - 8'd1;
                    m_oe = 1; m_dout = m_pcl;
                end
                AOP_SP_IN:  m_sp = s;
                default: ;
            endcase
        end
        e.ab = m_ab; e.ac = m_ac; e.ad = m_ad; e.pc = m_pc;
        e.oe = m_oe; e.dout = m_dout; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        #2;
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            cmp(e.tag, "ab_lo",    ab_lo,            e.ab);
            cmp(e.tag, "ab_carry", {7'd0, ab_carry}, {7'd0, e.ac});
            cmp(e.tag, "ab_down",  {7'd0, ab_down},  {7'd0, e.ad});
            cmp(e.tag, "pc_carry", {7'd0, pc_carry}, {7'd0, e.pc});
            cmp(e.tag, "db_oe",    {7'd0, db_oe},    {7'd0, e.oe});
            if (e.oe) cmp(e.tag, "db_out", db_out, e.dout);
        end
    end

    initial begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1; rdy = 1; aop = AOP_HOLD; db_in = 0; sb_in = 0; m_sp = 8'h00;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check_reset();                           // R1
        model_reset();
        step(AOP_PC_OUT,  8'h00, 8'h00, 1, "R1");  // PC low is 0

        step(AOP_SP_IN,   8'h00, 8'hFF, 1, "R11");
        step(AOP_SP_OUT,  8'h00, 8'h00, 1, "R10");
        step(AOP_PUSH,    8'h00, 8'h00, 1, "R8");
        step(AOP_PUSH,    8'h00, 8'h00, 1, "R8");
        step(AOP_PULL,    8'h00, 8'h00, 1, "R8");
        step(AOP_PULL,    8'h00, 8'h00, 1, "R8");
        step(AOP_SP_OUT,  8'h00, 8'h00, 1, "R10");

        step(AOP_LOAD_PC, 8'hFE, 8'h00, 1, "R6");
        step(AOP_PC_INC,  8'h00, 8'h00, 1, "R3");
        step(AOP_PC_INC,  8'h00, 8'h00, 1, "R3");  // wraps, pc_carry
        step(AOP_PC_OUT,  8'h00, 8'h00, 1, "R6");

        step(AOP_ZP,      8'h80, 8'h33, 1, "R4");
        step(AOP_ZP_IDX,  8'hF0, 8'h20, 1, "R4");  // wraps in page zero
        step(AOP_ABS_IDX, 8'hF0, 8'h20, 1, "R5");  // carry
        step(AOP_ABS_IDX, 8'h10, 8'h20, 1, "R5");
        step(AOP_ABS_IDX, 8'hFF, 8'h01, 1, "R5");

        step(AOP_LOAD_PC, 8'h10, 8'h00, 1, "R6");
        step(AOP_BRANCH,  8'hF0, 8'h00, 1, "R7");  // back, same page
        step(AOP_BRANCH,  8'hF0, 8'h00, 1, "R7");  // back, page borrow
        step(AOP_BRANCH,  8'h20, 8'h00, 1, "R7");  // forward, page carry
        step(AOP_BRANCH,  8'h05, 8'h00, 1, "R7");
        step(AOP_BRANCH,  8'h80, 8'h00, 1, "R7");  // largest backward

        step(AOP_LOAD_PC, 8'h3C, 8'h00, 1, "R9");
        step(AOP_PUSH_PCL,8'h00, 8'h00, 1, "R9");
        step(AOP_LOAD_PC, 8'h77, 8'h00, 1, "R9");  // drive overlaps reload
        step(AOP_HOLD,    8'h00, 8'h00, 1, "R9");

        step(AOP_PUSH_PCL,8'h00, 8'h00, 1, "R9");
        step(AOP_PC_INC,  8'h00, 8'h00, 0, "R12");
        step(AOP_BRANCH,  8'h40, 8'h11, 0, "R12");
        step(AOP_PC_INC,  8'h00, 8'h00, 1, "R3");

        step(AOP_ABS_IDX, 8'hF0, 8'h20, 1, "R5");
        step(5'd20,       8'h55, 8'h66, 1, "R2");  // unused code = hold
        step(AOP_ABS_IDX, 8'hF0, 8'h20, 1, "R5");
        step(AOP_HOLD,    8'h55, 8'h66, 1, "R2");
        step(5'd31,       8'h55, 8'h66, 1, "R2");
        step(AOP_PC_OUT,  8'h00, 8'h00, 1, "R2");

        // stack pointer survives a reset
        step(AOP_SP_IN,   8'h00, 8'h42, 1, "R11");
        @(negedge clk);
        rst = 1; aop = AOP_HOLD;
        repeat (2) @(negedge clk);
        rst = 0;
        #1;
        check_reset();
        model_reset();
        step(AOP_SP_OUT,  8'h00, 8'h00, 1, "R1");
        step(AOP_PC_OUT,  8'h00, 8'h00, 1, "R1");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule